// File: doc/BRIEF.md
# Asynchronous Burst ROM Read Controller

This block runs read bursts against an external ROM that has no clock input but can return a run of words from one aligned block quickly. A single request fetches one aligned block of four 32-bit words. The block keeps chip select and the read strobe low-active-equivalent (asserted) from the first beat to the last. During the burst it steps the word address one beat at a time. It returns each captured word on a parallel output with a one-cycle valid pulse and the beat number. A one-cycle done pulse closes the burst.

The first beat has a setup cycle, then a programmable number of wait cycles, then a capture cycle. Every later beat has its own, usually shorter, programmable wait count, then a capture cycle. An external wait input stretches any wait cycle for as long as it is held. The requester supplies the start address and both wait counts with the request. The block takes them at that moment and keeps them for the whole burst.

Top module: `burst_rom_reader`

## Requirements
- R1: While reset is held and after it is released, chip select, read strobe, data-valid and done are all 0 until a request is accepted.
- R2: A start pulse seen while idle begins a burst in the next cycle. Chip select and read strobe are then 1 without a gap until the capture cycle of beat 3, and they are 0 in the cycle after it.
- R3: During beat k the ROM address is the start address with its low 4 bits cleared, plus 4*k, so address bits [3:2] equal the beat number and bits [1:0] are 0.
- R4: Beat 0 lasts 2 + F cycles, where F is the first-beat wait count: one setup cycle, F wait cycles, and one capture cycle.
- R5: Each of beats 1 to 3 lasts N + 1 cycles, where N is the later-beat wait count: N wait cycles and one capture cycle. A count of 0 removes the wait cycles.
- R6: Both wait counts are taken at the accepted start. Changing them during a burst has no effect on its timing.
- R7: Each cycle in which the external wait input is 1 during a wait cycle adds one cycle to that wait. The input has no effect in setup or capture cycles, or while idle.
- R8: The ROM data present in the capture cycle of beat k is output in the next cycle, with data-valid at 1 for that cycle and the beat output equal to k.
- R9: Done is 1 for exactly one cycle, the cycle after the capture cycle of beat 3, together with that beat's data-valid.
- R10: A start pulse during a burst is ignored. A start pulse in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst request, sampled while idle |
| start_addr_i | input | AW | Byte address inside the block to fetch |
| first_wait_i | input | WW | Wait cycles for beat 0 |
| next_wait_i | input | WW | Wait cycles for beats 1 to 3 |
| ext_wait_i | input | 1 | Stretches the current wait cycle when 1 |
| rom_data_i | input | DW | Data returned by the ROM |
| rom_cs_o | output | 1 | Chip select, 1 = asserted |
| rom_rd_o | output | 1 | Read strobe, 1 = asserted |
| rom_addr_o | output | AW | ROM byte address of the current beat |
| rd_data_o | output | DW | Captured word |
| rd_valid_o | output | 1 | One-cycle pulse marking rd_data_o |
| rd_beat_o | output | BW | Beat number of rd_data_o |
| done_o | output | 1 | One-cycle pulse ending a burst |

## Verification
The bench builds the block with its defaults: a 24-bit address, 4-bit wait counts and four 32-bit beats. With 4-bit counts, wait values from 0 to 15 can be used. This covers the zero-wait case, in which beats run back to back with valid pulses in consecutive cycles, and long beats that the external wait input stretches further. The 24-bit address allows a block at the very top of the space, so a wrap past the block edge would be caught. It also makes unaligned start addresses visible in the low bits.

// File: rtl/brom_pkg.sv
package brom_pkg;

    // Wait counts a requester normally supplies
    localparam int unsigned DEF_FIRST_WAIT = 2;
    localparam int unsigned DEF_NEXT_WAIT  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT_FIRST,
        ST_BEAT_END,
        ST_WAIT_NEXT,
        ST_LAST_END
    } brom_state_e;

    // Capture state that closes a beat, depending on whether it is the last
    function automatic brom_state_e end_state(input logic is_last);
        return is_last ? ST_LAST_END : ST_BEAT_END;
    endfunction

    typedef struct packed {
        logic load;
        logic adv;
        logic cap;
        logic cap_last;
    } brom_ctl_t;

endpackage

// File: rtl/brom_fsm.sv
module brom_fsm
    import brom_pkg::*;
#(
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [WW-1:0] first_wait_i,
    input  logic [WW-1:0] next_wait_i,
    input  logic          ext_wait_i,
    input  logic          beat_last_i,
    input  logic          beat_pre_last_i,
    output brom_state_e   state_o,
    output brom_ctl_t     ctl_o
);

    localparam logic [WW-1:0] ONE = WW'(1);

    brom_state_e   st_q, st_n;
    logic [WW-1:0] cnt_q, cnt_n;
    logic [WW-1:0] fw_q, nw_q;

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        ctl_o = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_n       = ST_SETUP;
                    ctl_o.load = 1'b1;
                end
            end
            ST_SETUP: begin
                if (fw_q == '0) begin
                    st_n = ST_BEAT_END;
                end else begin
                    st_n  = ST_WAIT_FIRST;
                    cnt_n = fw_q;
                end
            end
            ST_WAIT_FIRST: begin
                if (!ext_wait_i) begin
                    if (cnt_q == ONE) st_n = ST_BEAT_END;
                    else              cnt_n = cnt_q - ONE;
                end
            end
            ST_BEAT_END: begin
                ctl_o.cap = 1'b1;
                ctl_o.adv = 1'b1;
                if (nw_q == '0) begin
                    st_n = end_state(beat_pre_last_i);
                end else begin
                    st_n  = ST_WAIT_NEXT;
                    cnt_n = nw_q;
                end
            end
            ST_WAIT_NEXT: begin
                if (!ext_wait_i) begin
                    if (cnt_q == ONE) st_n = end_state(beat_last_i);
                    else              cnt_n = cnt_q - ONE;
                end
            end
            ST_LAST_END: begin
                ctl_o.cap      = 1'b1;
                ctl_o.cap_last = 1'b1;
                st_n           = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            fw_q  <= '0;
            nw_q  <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            if (ctl_o.load) begin
                fw_q <= first_wait_i;
                nw_q <= next_wait_i;
            end
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/brom_addr_gen.sv
module brom_addr_gen #(
    parameter int AW    = 24,
    parameter int DW    = 32,
    parameter int BEATS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_i,
    input  logic                       adv_i,
    input  logic [AW-1:0]              start_addr_i,
    output logic [AW-1:0]              addr_o,
    output logic [$clog2(BEATS)-1:0]   beat_o,
    output logic                       last_o,
    output logic                       pre_last_o
);

    localparam int BW        = $clog2(BEATS);
    localparam int BYTE_BITS = $clog2(DW / 8);
    localparam int BLK_BITS  = BYTE_BITS + BW;
    localparam logic [AW-1:0] BLK_MASK = AW'((1 << BLK_BITS) - 1);
    localparam logic [BW-1:0] LAST_IDX = BW'(BEATS - 1);
    localparam logic [BW-1:0] PRE_IDX  = BW'(BEATS - 2);

    logic [AW-1:0] base_q;
    logic [BW-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (load_i) begin
            base_q <= start_addr_i & ~BLK_MASK;
            beat_q <= '0;
        end else if (adv_i) begin
            beat_q <= beat_q + BW'(1);
        end
    end

    // Beat number sits directly above the byte-lane bits
    assign addr_o     = base_q | AW'({beat_q, {BYTE_BITS{1'b0}}});
    assign beat_o     = beat_q;
    assign last_o     = (beat_q == LAST_IDX);
    assign pre_last_o = (beat_q == PRE_IDX);

endmodule

// File: rtl/brom_capture.sv
module brom_capture #(
    parameter int DW = 32,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_i,
    input  logic          cap_last_i,
    input  logic [BW-1:0] beat_i,
    input  logic [DW-1:0] rom_data_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o,
    output logic [BW-1:0] beat_o,
    output logic          done_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            valid_o <= 1'b0;
            beat_o  <= '0;
            done_o  <= 1'b0;
        end else begin
            valid_o <= cap_i;
            done_o  <= cap_last_i;
            if (cap_i) begin
                data_o <= rom_data_i;
                beat_o <= beat_i;
            end
        end
    end

endmodule

// File: rtl/burst_rom_reader.sv
module burst_rom_reader
    import brom_pkg::*;
#(
    parameter int AW    = 24,
    parameter int DW    = 32,
    parameter int WW    = 4,
    parameter int BEATS = 4,
    localparam int BW   = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [WW-1:0] first_wait_i,
    input  logic [WW-1:0] next_wait_i,
    input  logic          ext_wait_i,
    input  logic [DW-1:0] rom_data_i,
    output logic          rom_cs_o,
    output logic          rom_rd_o,
    output logic [AW-1:0] rom_addr_o,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_valid_o,
    output logic [BW-1:0] rd_beat_o,
    output logic          done_o
);

    brom_state_e   state;
    brom_ctl_t     ctl;
    logic [BW-1:0] beat;
    logic          beat_last, beat_pre_last;

    brom_fsm #(.WW(WW)) fsm_i (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .first_wait_i   (first_wait_i),
        .next_wait_i    (next_wait_i),
        .ext_wait_i     (ext_wait_i),
        .beat_last_i    (beat_last),
        .beat_pre_last_i(beat_pre_last),
        .state_o        (state),
        .ctl_o          (ctl)
    );

    brom_addr_gen #(.AW(AW), .DW(DW), .BEATS(BEATS)) addr_i (
        .clk         (clk),
        .rst         (rst),
        .load_i      (ctl.load),
        .adv_i       (ctl.adv),
        .start_addr_i(start_addr_i),
        .addr_o      (rom_addr_o),
        .beat_o      (beat),
        .last_o      (beat_last),
        .pre_last_o  (beat_pre_last)
    );

    brom_capture #(.DW(DW), .BW(BW)) cap_i (
        .clk       (clk),
        .rst       (rst),
        .cap_i     (ctl.cap),
        .cap_last_i(ctl.cap_last),
        .beat_i    (beat),
        .rom_data_i(rom_data_i),
        .data_o    (rd_data_o),
        .valid_o   (rd_valid_o),
        .beat_o    (rd_beat_o),
        .done_o    (done_o)
    );

    // Both strobes span the whole burst
    assign rom_cs_o = (state != ST_IDLE);
    assign rom_rd_o = (state != ST_IDLE);

endmodule

// File: rtl/burst_rom_reader_chk.sv
module burst_rom_reader_chk #(
    parameter int AW    = 24,
    parameter int DW    = 32,
    parameter int BEATS = 4,
    localparam int BW   = $clog2(BEATS),
    localparam int BYTE_BITS = $clog2(DW / 8),
    localparam int BLK_BITS  = BYTE_BITS + BW
) (
    input logic          clk,
    input logic          rst,
    input logic          rom_cs_o,
    input logic          rom_rd_o,
    input logic [AW-1:0] rom_addr_o,
    input logic          rd_valid_o,
    input logic [BW-1:0] rd_beat_o,
    input logic          done_o
);

    // R2
    cs_fall_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rom_cs_o) |-> done_o);

    // R2
    strobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
        rom_cs_o == rom_rd_o);

    // R3
    block_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rom_cs_o && $past(rom_cs_o)) |->
            rom_addr_o[AW-1:BLK_BITS] == $past(rom_addr_o[AW-1:BLK_BITS]));

    // R8
    valid_beat_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> ($past(rom_cs_o) && rd_beat_o == $past(rom_addr_o[BLK_BITS-1:BYTE_BITS])));

    // R9
    done_last_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (rd_valid_o && !rom_cs_o && rd_beat_o == BW'(BEATS - 1)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

bind burst_rom_reader burst_rom_reader_chk #(.AW(AW), .DW(DW), .BEATS(BEATS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rom_cs_o  (rom_cs_o),
    .rom_rd_o  (rom_rd_o),
    .rom_addr_o(rom_addr_o),
    .rd_valid_o(rd_valid_o),
    .rd_beat_o (rd_beat_o),
    .done_o    (done_o)
);

// File: tb/burst_rom_reader_tb_top.sv
module burst_rom_reader_tb_top;
    import brom_pkg::*;

    localparam int AW = 24;
    localparam int DW = 32;
    localparam int WW = 4;
    localparam int BEATS = 4;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [WW-1:0] first_wait_i = '0;
    logic [WW-1:0] next_wait_i = '0;
    logic          ext_wait_i = 1'b0;
    logic [DW-1:0] rom_data_i;
    logic          rom_cs_o, rom_rd_o, rd_valid_o, done_o;
    logic [AW-1:0] rom_addr_o;
    logic [DW-1:0] rd_data_o;
    logic [BW-1:0] rd_beat_o;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'hA5C3, ~a[23:8]};
    endfunction

    assign rom_data_i = rom_word(rom_addr_o);

    burst_rom_reader dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .first_wait_i(first_wait_i), .next_wait_i(next_wait_i),
        .ext_wait_i(ext_wait_i), .rom_data_i(rom_data_i),
        .rom_cs_o(rom_cs_o), .rom_rd_o(rom_rd_o), .rom_addr_o(rom_addr_o),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .rd_beat_o(rd_beat_o),
        .done_o(done_o)
    );

    // Reference model: a queue of expected bus cycles (0 setup, 1 wait, 2 capture)
    int            qk[$];
    int            qb[$];
    logic [AW-1:0] m_base = '0;
    logic          e_valid = 1'b0, e_done = 1'b0;
    int            e_beat = 0;
    logic [DW-1:0] e_data = '0;

    always @(posedge clk) begin
        logic nv, nd;
        nv = 1'b0;
        nd = 1'b0;
        if (rst) begin
            qk.delete();
            qb.delete();
        end else if (qk.size() == 0) begin
            if (start_i) begin
                m_base = {start_addr_i[AW-1:4], 4'b0000};
                qk.push_back(0); qb.push_back(0);
                for (int i = 0; i < int'(first_wait_i); i++) begin qk.push_back(1); qb.push_back(0); end
                qk.push_back(2); qb.push_back(0);
                for (int b = 1; b < BEATS; b++) begin
                    for (int i = 0; i < int'(next_wait_i); i++) begin qk.push_back(1); qb.push_back(b); end
                    qk.push_back(2); qb.push_back(b);
                end
            end
        end else if (!(qk[0] == 1 && ext_wait_i)) begin
            int k, b;
            k = qk.pop_front();
            b = qb.pop_front();
            if (k == 2) begin
                nv = 1'b1;
                e_beat = b;
                e_data = rom_word(m_base + AW'(4 * b));
                if (qk.size() == 0) nd = 1'b1;
            end
        end
        e_valid = nv;
        e_done  = nd;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic ecs;
            ecs = (qk.size() != 0);
            // R2 R4 R5 R6 R7 R10: strobe timing
            check(rom_cs_o == ecs, "R2 R4 R5 R6 R7 R10 chip select", 64'(rom_cs_o), 64'(ecs));
            check(rom_rd_o == ecs, "R2 read strobe", 64'(rom_rd_o), 64'(ecs));
            if (ecs) begin
                logic [AW-1:0] ea;
                ea = m_base + AW'(4 * qb[0]);
                check(rom_addr_o == ea, "R3 address", 64'(rom_addr_o), 64'(ea));
            end
            check(rd_valid_o == e_valid, "R8 data valid", 64'(rd_valid_o), 64'(e_valid));
            if (e_valid) begin
                check(rd_beat_o == BW'(e_beat), "R8 beat index", 64'(rd_beat_o), 64'(e_beat));
                check(rd_data_o == e_data, "R8 data", 64'(rd_data_o), 64'(e_data));
            end
            check(done_o == e_done, "R9 done", 64'(done_o), 64'(e_done));
        end
    end

    // mode bit0: jitter ext wait, bit1: scramble wait inputs, bit2: stray starts
    task automatic run_burst(input logic [AW-1:0] a, input int fw, input int nw, input int mode);
        int cs_cycles;
        @(negedge clk);
        start_addr_i = a;
        first_wait_i = WW'(fw);
        next_wait_i  = WW'(nw);
        start_i      = 1'b1;
        ext_wait_i   = (mode & 1) ? 1'($urandom % 2) : 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        cs_cycles = 0;
        while (rom_cs_o) begin
            cs_cycles++;
            if (mode & 1) ext_wait_i = 1'($urandom % 2);
            if (mode & 2) begin
                first_wait_i = WW'($urandom);
                next_wait_i  = WW'($urandom);
            end
            if (mode & 4) begin
                start_i      = 1'($urandom % 2);
                start_addr_i = AW'($urandom);
            end
            @(negedge clk);
            if (cs_cycles > 2000) break;
        end
        start_i    = 1'b0;
        ext_wait_i = 1'b0;
        if ((mode & 1) == 0) begin
            // R4 R5: burst length from the wait counts
            int exp_len;
            exp_len = (2 + fw) + (BEATS - 1) * (nw + 1);
            check(cs_cycles == exp_len, "R4 R5 burst length", 64'(cs_cycles), 64'(exp_len));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!rom_cs_o && !rom_rd_o && !rd_valid_o && !done_o, "R1 reset outputs",
              {60'd0, rom_cs_o, rom_rd_o, rd_valid_o, done_o}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!rom_cs_o && !done_o, "R1 idle after reset", {62'd0, rom_cs_o, done_o}, 64'd0);

        run_burst(24'h001234, DEF_FIRST_WAIT, DEF_NEXT_WAIT, 0);  // R3 unaligned
        run_burst(24'h00ABC0, 0, 0, 0);                           // R4 R5 zero waits
        run_burst(24'hFFFFF8, 15, 15, 0);                         // R3 top of space
        run_burst(24'h000100, 3, 2, 2);                           // R6
        run_burst(24'h020404, 3, 2, 1);                           // R7
        run_burst(24'h7777AC, 1, 0, 4);                           // R10
        // R10: start held through the done cycle is accepted there
        @(negedge clk);
        start_addr_i = 24'h300000;
        first_wait_i = 4'd1;
        next_wait_i  = 4'd1;
        start_i      = 1'b1;
        @(negedge clk);
        while (!done_o) @(negedge clk);
        start_addr_i = 24'h400010;
        @(negedge clk);
        start_i = 1'b0;
        while (rom_cs_o) @(negedge clk);
        for (int n = 0; n < 30; n++) begin
            run_burst(AW'($urandom), int'($urandom % 5), int'($urandom % 4), int'($urandom % 8));
        end
        repeat (3) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule